// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Register

This block holds a 14-bit configuration word for a telephone-line equaliser. The word is entered one bit at a time on a serial data line, under a slow serial clock. It goes into a shift register, and a separate holding latch drives the control fields. Bits shifted in stay in the shift register until an input strobe copies them into the holding latch. An output strobe copies the latch back into the shift register, so the active word can be read out serially. The serial output also lets several devices share one data line in a daisy chain.

The serial clock, the data line and both strobes are asynchronous to the fast system clock. Each passes through a synchroniser, and the block then detects serial-clock edges on the system clock. A small state machine sorts strobe activity into phases:
- IDLE: serial shifting is allowed.
- CAPTURE: input strobe active; the latch follows the shift register.
- READBACK: output strobe active; the shift register follows the latch.
- REJECT: a strobe was raised while the serial clock was high; it is ignored.

The transitions are:
- IDLE to CAPTURE when the input strobe is high and the serial clock is low.
- IDLE to READBACK when only the output strobe is high and the serial clock is low.
- IDLE to REJECT when either strobe is high while the serial clock is high.
- CAPTURE back to IDLE when the input strobe drops.
- READBACK back to IDLE when the output strobe drops.
- REJECT back to IDLE once both strobes are low.

Top module: `serial_ctl_reg`

## Requirements
- R1: Each rising serial-clock edge seen in IDLE moves the shift register one place toward bit 0 and puts the data input at bit 13. After 14 edges, the first bit sent sits at bit 0.
- R2: The serial output changes on falling serial-clock edges in IDLE, taking the current bit 0 of the shift register. Sampled just before each rising edge, it therefore returns the previous shift-register contents, bit 0 first.
- R3: The holding latch changes only in CAPTURE. Shifting a new word in leaves every control field unchanged.
- R4: The latch fields are laid out as follows: bit 0 is the pass flag; bits 4..1 are height; bits 8..5 are width; bits 12..9 are slope; bit 13 is the slope-extension flag. For each multi-bit field, the lower bit number is the LSB. The bypass output is 1 exactly when the pass flag is 0.
- R5: In READBACK the shift register is loaded from the latch and the serial output shows latch bit 0 at once. The next 14 serial clocks return the latch word, bit 0 first.
- R6: When both strobes are raised together while the serial clock is low, the input strobe wins. The latch takes the shift-register word.
- R7: A strobe raised while the serial clock is high leaves the latch unchanged. It is ignored until both strobes are low again.
- R8: Synchronous reset clears the shift register, the latch and the serial output to zero. The bypass output is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_i | input | 1 | synchronous reset, active high |
| sck_i | input | 1 | asynchronous serial clock |
| sid_i | input | 1 | asynchronous serial data in |
| lat_in_i | input | 1 | strobe: shift register to latch |
| lat_out_i | input | 1 | strobe: latch to shift register |
| sod_o | output | 1 | serial data out |
| bypass_o | output | 1 | 1 when the pass flag is 0 |
| height_o | output | FIELD_W | height field |
| width_o | output | FIELD_W | width field |
| slope_o | output | FIELD_W | slope field |
| slope_ext_o | output | 1 | slope-extension flag |

## Verification
The bench builds the block with FIELD_W = 4, which gives the 14-bit word, and SYNC_STAGES = 2. Every field boundary and the full daisy-chain length are therefore exercised at their real sizes. Each serial-clock phase is held for six system cycles, more than the synchroniser and edge-detect latency. This lets the bench check word-level results without depending on the exact latency. The strobe races are driven directly: a strobe raised under a high serial clock, and both strobes raised at once.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CAPTURE  = 2'd1,
        ST_READBACK = 2'd2,
        ST_REJECT   = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/serial_ctl_sync.sv
module serial_ctl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) pipe_q[0] <= '0;
        else       pipe_q[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) pipe_q[g] <= '0;
            else       pipe_q[g] <= pipe_q[g-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/serial_ctl_edge.sv
module serial_ctl_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/serial_ctl_fsm.sv
module serial_ctl_fsm
    import serial_ctl_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       sck_lvl_i,
    input  logic       sck_rise_i,
    input  logic       sck_fall_i,
    input  logic       lin_i,
    input  logic       lout_i,
    output ctl_state_e state_o,
    output logic       shift_en_o,
    output logic       emit_en_o,
    output logic       load_en_o,
    output logic       read_en_o
);

    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if ((lin_i | lout_i) & sck_lvl_i) state_d = ST_REJECT;
                else if (lin_i)                   state_d = ST_CAPTURE;
                else if (lout_i)                  state_d = ST_READBACK;
            end
            ST_CAPTURE:  if (!lin_i)           state_d = ST_IDLE;
            ST_READBACK: if (!lout_i)          state_d = ST_IDLE;
            ST_REJECT:   if (!lin_i && !lout_i) state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        shift_en_o = 1'b0;
        emit_en_o  = 1'b0;
        load_en_o  = 1'b0;
        read_en_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                shift_en_o = sck_rise_i;
                emit_en_o  = sck_fall_i;
            end
            ST_REJECT: begin
                shift_en_o = sck_rise_i;
                emit_en_o  = sck_fall_i;
            end
            ST_CAPTURE:  load_en_o = 1'b1;
            ST_READBACK: read_en_o = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/serial_ctl_core.sv
module serial_ctl_core #(
    parameter int WORD_W = 14
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sid_i,
    input  logic              shift_en_i,
    input  logic              emit_en_i,
    input  logic              load_en_i,
    input  logic              read_en_i,
    output logic [WORD_W-1:0] shreg_o,
    output logic [WORD_W-1:0] hold_o,
    output logic              sod_o
);

    logic [WORD_W-1:0] shreg_q, hold_q;
    logic              sod_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)           shreg_q <= '0;
        else if (read_en_i)  shreg_q <= hold_q;
        else if (shift_en_i) shreg_q <= {sid_i, shreg_q[WORD_W-1:1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)          hold_q <= '0;
        else if (load_en_i) hold_q <= shreg_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)          sod_q <= 1'b0;
        else if (read_en_i) sod_q <= hold_q[0];
        else if (emit_en_i) sod_q <= shreg_q[0];
    end

    assign shreg_o = shreg_q;
    assign hold_o  = hold_q;
    assign sod_o   = sod_q;

endmodule

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg
    import serial_ctl_pkg::*;
#(
    parameter int FIELD_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               sck_i,
    input  logic               sid_i,
    input  logic               lat_in_i,
    input  logic               lat_out_i,
    output logic               sod_o,
    output logic               bypass_o,
    output logic [FIELD_W-1:0] height_o,
    output logic [FIELD_W-1:0] width_o,
    output logic [FIELD_W-1:0] slope_o,
    output logic               slope_ext_o
);

    localparam int WORD_W  = 3 * FIELD_W + 2;
    localparam int PASS_B  = 0;
    localparam int HT_LSB  = 1;
    localparam int WD_LSB  = HT_LSB + FIELD_W;
    localparam int SL_LSB  = WD_LSB + FIELD_W;
    localparam int EXT_B   = SL_LSB + FIELD_W;

    logic [3:0]        raw_in, syn_out;
    logic              sck_s, sid_s, lin_s, lout_s;
    logic              sck_rise, sck_fall;
    logic              shift_en, emit_en, load_en, read_en;
    ctl_state_e        fsm_state;
    logic [WORD_W-1:0] shreg_w, hold_w;

    assign raw_in = {lat_out_i, lat_in_i, sid_i, sck_i};

    serial_ctl_sync #(.W(4), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_in),
        .q_o   (syn_out)
    );

    assign sck_s  = syn_out[0];
    assign sid_s  = syn_out[1];
    assign lin_s  = syn_out[2];
    assign lout_s = syn_out[3];

    serial_ctl_edge edge_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (sck_s),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    serial_ctl_fsm fsm_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sck_lvl_i  (sck_s),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .lin_i      (lin_s),
        .lout_i     (lout_s),
        .state_o    (fsm_state),
        .shift_en_o (shift_en),
        .emit_en_o  (emit_en),
        .load_en_o  (load_en),
        .read_en_o  (read_en)
    );

    serial_ctl_core #(.WORD_W(WORD_W)) core_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sid_i      (sid_s),
        .shift_en_i (shift_en),
        .emit_en_i  (emit_en),
        .load_en_i  (load_en),
        .read_en_i  (read_en),
        .shreg_o    (shreg_w),
        .hold_o     (hold_w),
        .sod_o      (sod_o)
    );

    assign bypass_o    = ~hold_w[PASS_B];
    assign height_o    = hold_w[HT_LSB +: FIELD_W];
    assign width_o     = hold_w[WD_LSB +: FIELD_W];
    assign slope_o     = hold_w[SL_LSB +: FIELD_W];
    assign slope_ext_o = hold_w[EXT_B];

endmodule

// File: rtl/serial_ctl_reg_chk.sv
module serial_ctl_reg_chk
    import serial_ctl_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              rise_i,
    input logic              fall_i,
    input logic              sid_i,
    input ctl_state_e        st_i,
    input logic [WORD_W-1:0] shreg_i,
    input logic [WORD_W-1:0] hold_i,
    input logic              sod_i
);

    // R1: a rising edge in IDLE moves the register one place
    p_shift_in_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && st_i == ST_IDLE) |=>
            (shreg_i[WORD_W-1] == $past(sid_i)) &&
            (shreg_i[WORD_W-2:0] == $past(shreg_i[WORD_W-1:1])));

    // R2: the serial output moves only on a falling edge or a readback
    p_sod_timing_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (sod_i != $past(sod_i)) |->
            ($past(fall_i) || $past(st_i == ST_READBACK)));

    // R3: the latch changes only in CAPTURE
    p_latch_guard_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_i != $past(hold_i)) |-> $past(st_i == ST_CAPTURE));

    // R5: readback reloads the register and the output bit
    p_readback_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == ST_READBACK) |=>
            (shreg_i == $past(hold_i)) && (sod_i == $past(hold_i[0])));

    // R7: a rejected strobe leaves the latch alone
    p_reject_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_i == ST_REJECT) |=> $stable(hold_i));

    // R8: reset clears the storage
    p_reset_clear_r8: assert property (@(posedge clk_i)
        rst_i |=> (hold_i == '0) && (shreg_i == '0) && !sod_i);

endmodule

bind serial_ctl_reg serial_ctl_reg_chk #(.WORD_W(WORD_W)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rise_i  (sck_rise),
    .fall_i  (sck_fall),
    .sid_i   (sid_s),
    .st_i    (fsm_state),
    .shreg_i (shreg_w),
    .hold_i  (hold_w),
    .sod_i   (sod_o)
);

// File: tb/serial_ctl_reg_tb.sv
module serial_ctl_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int FW         = 4;
    localparam int WW         = 3 * FW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, sid = 1'b0, lin = 1'b0, lout = 1'b0;
    logic sod, bypass, ext;
    logic [FW-1:0] height, width, slope;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_ctl_reg #(.FIELD_W(FW), .SYNC_STAGES(2)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .sck_i       (sck),
        .sid_i       (sid),
        .lat_in_i    (lin),
        .lat_out_i   (lout),
        .sod_o       (sod),
        .bypass_o    (bypass),
        .height_o    (height),
        .width_o     (width),
        .slope_o     (slope),
        .slope_ext_o (ext)
    );

    // Expected output vector from a word, per the R4 layout
    function automatic logic [WW:0] exp_fields(input logic [WW-1:0] w);
        logic [WW:0] r;
        r[0]              = ~w[0];
        r[1 +: FW]        = w[1 +: FW];
        r[1+FW +: FW]     = w[1+FW +: FW];
        r[1+2*FW +: FW]   = w[1+2*FW +: FW];
        r[1+3*FW]         = w[1+3*FW];
        return r;
    endfunction

    function automatic logic [WW:0] act_fields();
        return {ext, slope, width, height, bypass};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit; obs is SOD sampled just before the rising edge
    task automatic shift_bit(input logic b, output logic obs);
        @(negedge clk); sid = b;
        wait_clk(HALF);
        obs = sod;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic shift_word(input logic [WW-1:0] w, output logic [WW-1:0] obs);
        for (int i = 0; i < WW; i++) begin
            logic o;
            shift_bit(w[i], o);
            obs[i] = o;
        end
        wait_clk(HALF);
    endtask

    task automatic strobe(input logic a, input logic b);
        @(negedge clk); lin = a; lout = b;
        wait_clk(8);
        lin = 1'b0; lout = 1'b0;
        wait_clk(8);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [WW-1:0] obs, w, w2, held;
        void'($urandom(32'h5EED));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R8 reset state
        check(act_fields() == exp_fields('0), "R8 fields", act_fields(), exp_fields('0));
        check(bypass == 1'b1, "R8 bypass", bypass, 1);
        check(sod == 1'b0, "R8 sod", sod, 0);

        // R1 R3 R4: directed word with distinct fields
        w = 14'b1_0110_1001_1100_1;
        shift_word(w, obs);
        check(act_fields() == exp_fields('0), "R3 fields held during shift", act_fields(), exp_fields('0));
        strobe(1'b1, 1'b0);
        check(act_fields() == exp_fields(w), "R1 R4 capture", act_fields(), exp_fields(w));
        held = w;

        // R2 daisy chain: shifting returns the previous register contents
        w2 = 14'h2A5C;
        shift_word(w2, obs);
        check(obs == w, "R2 chain out", obs, w);
        check(act_fields() == exp_fields(held), "R3 hold", act_fields(), exp_fields(held));

        // R5 readback
        strobe(1'b0, 1'b1);
        check(sod == held[0], "R5 first bit", sod, held[0]);
        shift_word(14'h0, obs);
        check(obs == held, "R5 readback word", obs, held);

        // R6 both strobes: input strobe wins
        w = 14'h1F0B;
        shift_word(w, obs);
        strobe(1'b1, 1'b1);
        check(act_fields() == exp_fields(w), "R6 priority", act_fields(), exp_fields(w));
        held = w;

        // R7 strobe while SCK high is ignored
        shift_word(14'h0333, obs);
        @(negedge clk); sck = 1'b1;
        wait_clk(HALF);
        lin = 1'b1;
        wait_clk(8);
        @(negedge clk); sck = 1'b0;   // strobe still high after SCK drops
        wait_clk(8);
        lin = 1'b0;
        wait_clk(8);
        check(act_fields() == exp_fields(held), "R7 reject", act_fields(), exp_fields(held));

        // R4 pass flag zero and one
        shift_word(14'h0000, obs);
        strobe(1'b1, 1'b0);
        check(bypass == 1'b1, "R4 bypass on", bypass, 1);
        shift_word(14'h0001, obs);
        strobe(1'b1, 1'b0);
        check(bypass == 1'b0, "R4 bypass off", bypass, 0);
        held = 14'h0001;

        // random words: capture, hold, readback
        for (int k = 0; k < 16; k++) begin
            w = WW'($urandom());
            shift_word(w, obs);
            if (k % 3 == 0) begin
                check(act_fields() == exp_fields(held), "R3 random hold", act_fields(), exp_fields(held));
            end
            strobe(1'b1, 1'b0);
            check(act_fields() == exp_fields(w), "R1 random capture", act_fields(), exp_fields(w));
            held = w;
            if (k % 4 == 1) begin
                strobe(1'b0, 1'b1);
                shift_word(WW'($urandom()), obs);
                check(obs == held, "R5 random readback", obs, held);
            end
        end

        // R8 reset after activity
        @(negedge clk); rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(3);
        check(act_fields() == exp_fields('0), "R8 re-reset", act_fields(), exp_fields('0));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule